// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block derives the time-quantum enable of a CAN node from the system clock and walks every bit through three segments. A single-quantum synchronization segment comes first. Time segment 1 follows and holds the propagation and first phase buffer. Time segment 2, the second phase buffer, comes last. The block pulses a transmit-point strobe when a synchronization segment begins. It pulses a sample strobe at the end of time segment 1, and at that moment it latches the received bit, either as one sample or as a two-of-three vote.

The received line is sampled once per quantum. A recessive-to-dominant change seen while the bus is flagged idle restarts the bit (hard synchronization). During a frame, the first such change in a bit moves the bit boundary by at most the jump width: time segment 1 is lengthened when the edge is late, and time segment 2 is shortened or the bit is closed when the edge is early. The configuration fields come straight from a register bank. An illegal combination raises an error flag, and that flag keeps all timing counters cleared.

Top module: `can_bit_timer`

## Requirements
- R1: `cfg_err` reflects, one clock after the fields change, that the configuration is illegal. The configuration is legal only when all of these hold: `cfg_tseg1` ≥ 3, `cfg_tseg2` ≥ 1, `cfg_tseg2` ≥ `cfg_sjw`, `cfg_tseg1` > `cfg_tseg2`, and `cfg_tseg1`+`cfg_tseg2`+3 ≥ 8.
- R2: While `cfg_err` is high, `tq_tick`, `sample_stb` and `tx_stb` stay low, and timing restarts from a fresh bit once the flag clears.
- R3: `tq_tick` is a single-cycle pulse repeating every 2×(`cfg_brp`+1) clock cycles.
- R4: With no edges, a bit lasts 3+`cfg_tseg1`+`cfg_tseg2` quanta. `tx_stb` pulses once when each synchronization segment begins. `sample_stb` pulses (`cfg_tseg2`+1) quanta before the next `tx_stb`, and never in the same cycle as it.
- R5: A recessive-to-dominant edge seen in quantum k (k = 1 … `cfg_tseg1`+1, counting the sync quantum as 0) lengthens the bit by min(k, `cfg_sjw`+1) quanta.
- R6: An edge seen in a time-segment-2 quantum with phase error e = (bit length − k) ≤ `cfg_sjw`+1 ends the bit at once. That quantum becomes the sync quantum of the next bit, and no `tx_stb` is issued for it.
- R7: An edge in time segment 2 with e > `cfg_sjw`+1 shortens the bit by exactly `cfg_sjw`+1 quanta.
- R8: An edge in the synchronization quantum causes no correction. Only the first edge in a bit is acted on.
- R9: Only recessive-to-dominant changes (`rx` 1 then 0, where 1 means recessive) count as edges. A dominant-to-recessive change does not move the bit boundary.
- R10: With `bus_idle` high, an edge in any quantum k makes that quantum the sync quantum of a new bit. The next `tx_stb` therefore follows after (k + bit length) quanta.
- R11: `rx_bit` updates at each sample point. With `cfg_triple`=0 it takes `rx` in the last quantum of time segment 1. With `cfg_triple`=1 it takes the majority of `rx` over that quantum and the two before it.
- R12: During and right after reset, `cfg_err`, `tq_tick`, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_brp | input | 6 | Prescaler code; quantum = 2×(code+1) clocks |
| cfg_tseg1 | input | 4 | Time segment 1 code; length = code+1 quanta |
| cfg_tseg2 | input | 3 | Time segment 2 code; length = code+1 quanta |
| cfg_sjw | input | 2 | Jump width code; limit = code+1 quanta |
| cfg_triple | input | 1 | 1 = two-of-three sampling, 0 = single sample |
| bus_idle | input | 1 | High while the bus is idle; edges then hard-synchronize |
| rx | input | 1 | Received bus level, already synchronized (1 = recessive) |
| cfg_err | output | 1 | Illegal configuration flag |
| tq_tick | output | 1 | One-cycle pulse per time quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| tx_stb | output | 1 | Pulse at the start of each synchronization segment |
| rx_bit | output | 1 | Bit value taken at the last sample point |

## Verification
The bench builds the unit with its default field widths: 6-bit prescaler, 4-bit and 3-bit segment codes, and a 2-bit jump width. At these widths every one of the 512 segment and jump-width code combinations can be checked for legality, and all 64 prescaler codes can be timed. Every legal segment pair is run for bit length and sample position. For three segment shapes under each legal jump width, an edge is placed in every quantum of the bit, both in a frame and with the bus idle, so the late, early-within-limit, early-beyond-limit and sync-segment cases all meet their boundaries. All eight three-quantum patterns at the sample point are run in both sampling modes.

// File: rtl/cbt_pkg.sv
// Shared types and helpers of the CAN bit timing unit.
// Assumes: nothing beyond IEEE 1800-2017.
package cbt_pkg;

    // Segment that the current time quantum belongs to.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

    // Two-of-three vote.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cbt_cfg_check.sv
// Checks the segment and jump-width codes against the legal limits and
// registers the result as an error flag.
// Assumes: TS1_W is the widest of the three code fields.
module cbt_cfg_check #(
    parameter int TS1_W   = 4,
    parameter int TS2_W   = 3,
    parameter int SJW_W   = 2,
    parameter int TS1_MIN = 3,
    parameter int TS2_MIN = 1,
    parameter int BIT_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             cfg_err
);

    localparam int SUM_W = TS1_W + 2;

    logic [SUM_W-1:0] a_len;
    logic [SUM_W-1:0] b_len;
    logic [SUM_W-1:0] j_len;
    logic             legal;

    // Widen the codes and evaluate every limit and cross-check.
    always_comb begin
        a_len = SUM_W'(tseg1);
        b_len = SUM_W'(tseg2);
        j_len = SUM_W'(sjw);
        legal = (a_len >= SUM_W'(TS1_MIN)) &&
                (b_len >= SUM_W'(TS2_MIN)) &&
                (b_len >= j_len) &&
                (a_len > b_len) &&
                ((a_len + b_len + SUM_W'(3)) >= SUM_W'(BIT_MIN));
    end

    // Register the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= !legal;
    end

endmodule

// File: rtl/cbt_prescaler.sv
// Divides the system clock into time quanta: one-cycle tick every
// 2*(brp+1) cycles. Held cleared while hold is high.
// Assumes: brp changes only under reset or hold; the >= compare recovers anyway.
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);

    localparam int CW = BRP_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = {brp, 1'b1};

    // Count clocks and emit the quantum pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/cbt_sampler.sv
// Keeps the bus levels of the last two quanta, flags a recessive-to-dominant
// change at the quantum boundary and forms the single or voted sample.
// Assumes: rx is already synchronized to clk; 1 is recessive.
module cbt_sampler
    import cbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic rx,
    input  logic triple,
    output logic fall_det,
    output logic samp_val
);

    logic [1:0] hist;   // hist[0] is the level of the previous quantum

    // Shift in the bus level once per quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) hist <= 2'b11;
        else if (tick)      hist <= {hist[0], rx};
    end

    // Edge and sample value for the quantum now ending.
    always_comb begin
        fall_det = tick && hist[0] && !rx;
        samp_val = triple ? maj3(hist[1], hist[0], rx) : rx;
    end

endmodule

// File: rtl/cbt_bit_seq.sv
// Sequences each bit through sync, time segment 1 and time segment 2 on
// quantum ticks, applies hard synchronization and bounded resynchronization,
// and issues the sample and transmit-point strobes.
// Assumes: at most one resynchronization per bit; SJW_W <= TS1_W.
module cbt_bit_seq
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic             fall_det,
    input  logic             bus_idle,
    input  logic             samp_val,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             rx_bit
);

    localparam int CNT_W = TS1_W + 1;
    localparam int EXT_W = SJW_W + 1;

    seg_e             seg, n_seg;
    logic [CNT_W-1:0] cnt, n_cnt;
    logic [EXT_W-1:0] ext, n_ext;     // quanta added to time segment 1
    logic [EXT_W-1:0] cut, n_cut;     // quanta removed from time segment 2
    logic             done, n_done;   // this bit has used its resync
    logic [CNT_W-1:0] jump_len;
    logic [CNT_W-1:0] perr;
    logic [CNT_W-1:0] t1_last;
    logic [CNT_W-1:0] t2_last;
    logic             restart;
    logic             go_smp;
    logic             go_tx;

    // Work out the phase correction, then the next quantum position.
    always_comb begin
        n_seg    = seg;
        n_cnt    = cnt;
        n_ext    = ext;
        n_cut    = cut;
        n_done   = done;
        go_smp   = 1'b0;
        go_tx    = 1'b0;
        restart  = 1'b0;
        perr     = '0;
        jump_len = CNT_W'(sjw) + CNT_W'(1);

        if (fall_det && bus_idle) begin
            restart = 1'b1;
        end else if (fall_det && !done) begin
            n_done = 1'b1;
            case (seg)
                SEG_TS1: begin
                    perr  = cnt + CNT_W'(1);
                    n_ext = (perr < jump_len) ? EXT_W'(perr) : EXT_W'(jump_len);
                end
                SEG_TS2: begin
                    perr = CNT_W'(tseg2) + CNT_W'(1) - cnt;
                    if (perr <= jump_len) restart = 1'b1;
                    else                  n_cut   = EXT_W'(jump_len);
                end
                default: ;
            endcase
        end

        t1_last = CNT_W'(tseg1) + CNT_W'(n_ext);
        t2_last = CNT_W'(tseg2) - CNT_W'(n_cut);

        if (restart) begin
            n_seg  = SEG_TS1;
            n_cnt  = '0;
            n_ext  = '0;
            n_cut  = '0;
            n_done = 1'b1;
        end else begin
            case (seg)
                SEG_SYNC: begin
                    n_seg = SEG_TS1;
                    n_cnt = '0;
                end
                SEG_TS1: begin
                    if (cnt == t1_last) begin
                        n_seg  = SEG_TS2;
                        n_cnt  = '0;
                        go_smp = 1'b1;
                    end else begin
                        n_cnt = cnt + CNT_W'(1);
                    end
                end
                SEG_TS2: begin
                    if (cnt == t2_last) begin
                        n_seg  = SEG_SYNC;
                        n_cnt  = '0;
                        n_ext  = '0;
                        n_cut  = '0;
                        n_done = 1'b0;
                        go_tx  = 1'b1;
                    end else begin
                        n_cnt = cnt + CNT_W'(1);
                    end
                end
                default: begin
                    n_seg = SEG_SYNC;
                    n_cnt = '0;
                end
            endcase
        end
    end

    // Advance the position on each quantum and register the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            seg        <= SEG_SYNC;
            cnt        <= '0;
            ext        <= '0;
            cut        <= '0;
            done       <= 1'b0;
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            sample_stb <= tick && go_smp;
            tx_stb     <= tick && go_tx;
            if (tick) begin
                seg  <= n_seg;
                cnt  <= n_cnt;
                ext  <= n_ext;
                cut  <= n_cut;
                done <= n_done;
                if (go_smp) rx_bit <= samp_val;
            end
        end
    end

endmodule

// File: rtl/can_bit_timer.sv
// Top of the CAN bit timing unit: configuration check, quantum prescaler,
// bus sampler and bit sequencer. All timing is cleared while the
// configuration is illegal.
// Assumes: rx is synchronized to clk by the caller.
module can_bit_timer #(
    parameter int BRP_W   = 6,
    parameter int TS1_W   = 4,
    parameter int TS2_W   = 3,
    parameter int SJW_W   = 2,
    parameter int TS1_MIN = 3,
    parameter int TS2_MIN = 1,
    parameter int BIT_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [TS1_W-1:0] cfg_tseg1,
    input  logic [TS2_W-1:0] cfg_tseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_triple,
    input  logic             bus_idle,
    input  logic             rx,
    output logic             cfg_err,
    output logic             tq_tick,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             rx_bit
);

    logic fall_det;
    logic samp_val;

    cbt_cfg_check #(
        .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W),
        .TS1_MIN(TS1_MIN), .TS2_MIN(TS2_MIN), .BIT_MIN(BIT_MIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .tseg1(cfg_tseg1), .tseg2(cfg_tseg2), .sjw(cfg_sjw),
        .cfg_err(cfg_err)
    );

    cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(cfg_err),
        .brp(cfg_brp), .tick(tq_tick)
    );

    cbt_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .hold(cfg_err), .tick(tq_tick),
        .rx(rx), .triple(cfg_triple),
        .fall_det(fall_det), .samp_val(samp_val)
    );

    cbt_bit_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(cfg_err), .tick(tq_tick),
        .fall_det(fall_det), .bus_idle(bus_idle), .samp_val(samp_val),
        .tseg1(cfg_tseg1), .tseg2(cfg_tseg2), .sjw(cfg_sjw),
        .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
    );

endmodule

// File: rtl/cbt_checker.sv
// Port-level properties of the CAN bit timing unit, bound to the top.
module cbt_checker #(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TS1_W-1:0] cfg_tseg1,
    input logic [TS2_W-1:0] cfg_tseg2,
    input logic [SJW_W-1:0] cfg_sjw,
    input logic             cfg_err,
    input logic             tq_tick,
    input logic             sample_stb,
    input logic             tx_stb
);

    assert_seg_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(cfg_tseg1) <= TS1_W'($past(cfg_tseg2)))) |-> cfg_err);

    assert_jump_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (TS1_W'($past(cfg_sjw)) > TS1_W'($past(cfg_tseg2)))) |-> cfg_err);

    assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> !(tq_tick || sample_stb || tx_stb));

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> !tq_tick);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    assert_strobe_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || tx_stb) |-> $past(tq_tick));

endmodule

bind can_bit_timer cbt_checker #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
    .cfg_err(cfg_err), .tq_tick(tq_tick),
    .sample_stb(sample_stb), .tx_stb(tx_stb)
);

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = '0;
    logic [3:0] cfg_tseg1 = 4'd7;
    logic [2:0] cfg_tseg2 = 3'd3;
    logic [1:0] cfg_sjw = '0;
    logic       cfg_triple = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx = 1'b1;
    logic       cfg_err, tq_tick, sample_stb, tx_stb, rx_bit;

    int nvec = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    can_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
        .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .cfg_triple(cfg_triple),
        .bus_idle(bus_idle), .rx(rx), .cfg_err(cfg_err), .tq_tick(tq_tick),
        .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_legal(input int t1, input int t2, input int sj);
        return (t1 >= 3) && (t2 >= 1) && (t2 >= sj) && (t1 > t2) && (t1 + t2 + 3 >= 8);
    endfunction

    // Expected bit length in quanta for a falling edge first seen in quantum k.
    function automatic int exp_len(input int t1, input int t2, input int sj,
                                   input int k, input bit idle);
        int tl1, tl2, n, s, e;
        tl1 = t1 + 1; tl2 = t2 + 1; n = 1 + tl1 + tl2; s = sj + 1;
        if (idle)     return k + n;
        if (k == 0)   return n;
        if (k <= tl1) return n + ((k < s) ? k : s);
        e = n - k;
        if (e <= s)   return k + n;
        return n - s;
    endfunction

    // Reset, configure, then time one bit between two tx strobes while
    // driving rx per quantum from mask (bit i = level in quantum i).
    task automatic run_bit(input int t1, input int t2, input int sj, input int br,
                           input logic trip, input logic idle, input logic pre,
                           input logic [63:0] mask, output int len, output int soff);
        int i, n, sc;
        bit pend, got;
        rst_n = 1'b0;
        cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2); cfg_sjw = 2'(sj); cfg_brp = 6'(br);
        cfg_triple = trip; bus_idle = idle; rx = pre;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        len = -1; soff = -1;
        n = 0; got = 0;
        while (!got && n < 3000) begin
            @(negedge clk); n++;
            if (tx_stb) got = 1;
        end
        if (!got) return;
        rx = mask[0]; i = 0; pend = 0; n = 0; sc = -1; got = 0;
        while (!got && n < 3000) begin
            @(negedge clk); n++;
            if (tx_stb) got = 1;
            else begin
                if (pend) begin
                    if (i < 63) i++;
                    rx = mask[i];
                    pend = 0;
                end
                if (tq_tick) pend = 1;
                if (sample_stb) sc = n;
            end
        end
        if (got) begin
            len = n;
            if (sc >= 0) soff = n - sc;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int len, soff, tl1, tl2, n, p, cyc, act;
        logic [63:0] m;
        logic expv;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(!cfg_err && !tq_tick && !sample_stb && !tx_stb && rx_bit, "R12 reset outputs",
              {cfg_err, tq_tick, sample_stb, tx_stb, rx_bit}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cfg_err && !tq_tick && !sample_stb && !tx_stb && rx_bit, "R12 after release",
              {cfg_err, tq_tick, sample_stb, tx_stb, rx_bit}, 1);

        // R1: every segment and jump-width code combination
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 8; b++)
                for (int j = 0; j < 4; j++) begin
                    cfg_tseg1 = 4'(a); cfg_tseg2 = 3'(b); cfg_sjw = 2'(j);
                    @(negedge clk); @(negedge clk);
                    check(cfg_err == !is_legal(a, b, j), "R1 legality", cfg_err, !is_legal(a, b, j));
                end

        // R2: illegal setting silences all timing outputs
        cfg_tseg1 = 4'd2; cfg_tseg2 = 3'd1; cfg_sjw = 2'd0; cfg_brp = 6'd0;
        repeat (3) @(negedge clk);
        act = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (tq_tick || sample_stb || tx_stb) act++;
        end
        check(act == 0, "R2 outputs held", act, 0);
        cfg_tseg1 = 4'd7;
        act = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (tq_tick) act++;
        end
        check(act > 0, "R2 resume after clear", act, 1);

        // R3: every prescaler code
        cfg_tseg1 = 4'd7; cfg_tseg2 = 3'd3;
        for (int br = 0; br < 64; br++) begin
            rst_n = 1'b0; cfg_brp = 6'(br);
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            cyc = 0;
            while (!tq_tick && cyc < 300) begin @(negedge clk); cyc++; end
            @(negedge clk);
            check(!tq_tick, "R3 tick width", tq_tick, 0);
            cyc = 1;
            while (!tq_tick && cyc < 300) begin @(negedge clk); cyc++; end
            check(cyc == 2 * (br + 1), "R3 tick period", cyc, 2 * (br + 1));
        end

        // R4: every legal segment pair, no edges
        for (int a = 3; a < 16; a++)
            for (int b = 1; b < 8; b++)
                if (is_legal(a, b, 0)) begin
                    run_bit(a, b, 0, 0, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, len, soff);
                    check(len == 2 * (a + b + 3), "R4 bit length", len, 2 * (a + b + 3));
                    check(soff == 2 * (b + 1), "R4 sample to tx", soff, 2 * (b + 1));
                end
        run_bit(9, 4, 0, 2, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, len, soff);
        check(len == 6 * 16, "R4 bit length scaled prescaler", len, 6 * 16);

        // R5 R6 R7 R8 R10: edge in every quantum, framed and idle
        for (int cfgi = 0; cfgi < 3; cfgi++) begin
            int t1, t2;
            t1 = (cfgi == 0) ? 7 : (cfgi == 1) ? 15 : 4;
            t2 = (cfgi == 0) ? 3 : (cfgi == 1) ? 7 : 1;
            tl1 = t1 + 1; tl2 = t2 + 1; n = 1 + tl1 + tl2;
            for (int sj = 0; sj < 4; sj++)
                if (is_legal(t1, t2, sj))
                    for (int idle = 0; idle < 2; idle++)
                        for (int k = 0; k < n; k++) begin
                            m = (64'd1 << k) - 64'd1;
                            run_bit(t1, t2, sj, 0, 1'b0, idle[0], 1'b1, m, len, soff);
                            p = 2 * exp_len(t1, t2, sj, k, idle[0]);
                            if (idle != 0)
                                check(len == p, "R10 hard sync", len, p);
                            else if (k == 0)
                                check(len == p, "R8 edge in sync segment", len, p);
                            else if (k <= tl1)
                                check(len == p, "R5 late edge", len, p);
                            else if (n - k <= sj + 1)
                                check(len == p, "R6 early edge ends bit", len, p);
                            else
                                check(len == p, "R7 early edge shortens", len, p);
                        end
        end

        // R8: second edge in the same bit is ignored
        m = 64'h0;
        m[0] = 1'b1; m[2] = 1'b1; m[3] = 1'b1;
        run_bit(7, 3, 3, 0, 1'b0, 1'b0, 1'b1, m, len, soff);
        check(len == 2 * (13 + 1), "R8 one resync per bit", len, 2 * 14);

        // R9: dominant-to-recessive change does not resync
        m = ~((64'd1 << 3) - 64'd1);
        run_bit(7, 3, 3, 0, 1'b0, 1'b0, 1'b0, m, len, soff);
        check(len == 2 * 13, "R9 rising change ignored", len, 2 * 13);

        // R11: all three-quantum patterns at the sample point, both modes
        for (int trip = 0; trip < 2; trip++)
            for (int pat = 0; pat < 8; pat++) begin
                m = 64'hFFFF_FFFF_FFFF_FFFF;
                for (int q = 0; q < 6; q++) m[q] = 1'b0;
                m[6] = pat[2]; m[7] = pat[1]; m[8] = pat[0];
                run_bit(7, 3, 1, 0, trip[0], 1'b0, 1'b1, m, len, soff);
                expv = (trip != 0) ? ((pat[2] & pat[1]) | (pat[2] & pat[0]) | (pat[1] & pat[0]))
                                   : pat[0];
                check(rx_bit == expv, "R11 sampled value", rx_bit, expv);
                check(len == 2 * 13, "R11 bit length unchanged", len, 2 * 13);
            end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule